// File: doc/BRIEF.md
# 40-bit word-placement shifter

The block shifts a 16-bit operand by a signed 8-bit shift code and stores the outcome in a 40-bit result register. The operand is first placed in one half of a 32-bit field at the bottom of the 40-bit word: the upper half (bits 31:16) or the lower half (bits 15:0). It is then moved left for a positive code or right for a negative code. Three operations are offered: an arithmetic shift that extends the sign of the operand, a logical shift that fills with zeros, and a normalize that negates the code before shifting.

The OR-merge option combines the new shifted word with the current register contents instead of overwriting it. A 32-bit value can therefore be shifted in two cycles: the upper word goes in with an arithmetic shift in the upper half, then the lower word goes in with a logical shift in the lower half, with merging on. A condition input that is low turns the cycle into a no-op. One overflow/underflow flag reports whether the shift discarded information. The result and the flag appear one clock after the inputs are sampled.

Top module: `shf_word_shifter`

## Requirements
- R1: While rst_ni is low, result_o and ovf_o are 0.
- R2: With hi_i=1 the operand is placed at bits 31:16 and bits 15:0 are zero. With hi_i=0 it is placed at bits 15:0. Bits above the operand carry its extension.
- R3: code_i is two's complement. A positive value shifts left by that many bits and a negative value shifts right by its magnitude. Bits moved past bit 39 or bit 0 are lost, so shifts of 40 or more leave only fill.
- R4: Arithmetic shift (op_i=0) extends operand bit 15 up to bit 39 and fills with zeros from the right. A right shift brings in copies of bit 39.
- R5: Logical shift (op_i=1, and the unused code 3) zero-extends the operand and fills with zeros on both sides.
- R6: Normalize (op_i=2) shifts by the negated code, so code -128 is a left shift of 128. In the upper half it extends the sign as in R4. In the lower half it zero-extends and zero-fills as in R5.
- R7: With or_i=1 the new shifted word is ORed into result_o. With or_i=0 it replaces result_o.
- R8: When cond_i=0, result_o and ovf_o keep their values.
- R9: ovf_o is set when a bit is lost. On a right shift this is any discarded low bit that is 1. On a left shift it is any discarded high bit that differs from the new bit 39 (arithmetic) or that is 1 (logical). With a left shift of 40 or more, this reduces to any nonzero placed word. Otherwise ovf_o is cleared, including for code 0.
- R10: An arithmetic shift of the upper word in the upper half, followed by a logical shift with OR of the lower word in the lower half using the same code, equals the arithmetic shift of the sign-extended 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_i | input | 1 | Execute this cycle; low makes it a no-op |
| op_i | input | 2 | 0 arithmetic, 1 logical, 2 normalize |
| hi_i | input | 1 | 1 places the operand in the upper half, 0 in the lower half |
| or_i | input | 1 | OR the shifted word into the result |
| operand_i | input | 16 | Operand to shift |
| code_i | input | 8 | Signed shift code |
| result_o | output | 40 | Result register |
| ovf_o | output | 1 | Overflow/underflow flag of the last executed shift |

## Verification
The properties assume that every control input is at a known level at each rising edge. They also assume that op_i is one of the three defined codes whenever the opcode-specific properties apply. The bench changes inputs only at falling edges and always drives defined values. cond_i is held low between operations, so an operation takes effect only in the one cycle it was issued. Random cases draw op_i only from the defined codes and sweep code_i across its whole signed range. This covers the sign extremes and the shifts past 40 bits.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SHF_ASH  = 2'd0,
    SHF_LSH  = 2'd1,
    SHF_NORM = 2'd2
  } shf_op_e;
endpackage

// File: rtl/shf_place.sv
module shf_place #(
  parameter int DATA_W = 16,
  parameter int RES_W  = 40
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic              hi_i,
  input  logic              arith_i,
  output logic [RES_W-1:0]  placed_o
);
  localparam int EXT_W = RES_W - DATA_W;

  logic [RES_W-1:0] ext;

  always_comb begin
    ext      = {{EXT_W{arith_i & operand_i[DATA_W-1]}}, operand_i};
    placed_o = hi_i ? (ext << DATA_W) : ext;
  end
endmodule

// File: rtl/shf_code.sv
module shf_code #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              negate_i,
  output logic              left_o,
  output logic [CODE_W:0]   amt_o
);
  logic [CODE_W:0] code_ext;
  logic [CODE_W:0] eff;

  always_comb begin
    code_ext = {code_i[CODE_W-1], code_i};
    // one extra bit so that negating the most negative code stays positive
    eff      = negate_i ? (~code_ext + 1'b1) : code_ext;
    left_o   = ~eff[CODE_W];
    amt_o    = eff[CODE_W] ? (~eff + 1'b1) : eff;
  end
endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
  parameter int RES_W = 40,
  parameter int AMT_W = 9
) (
  input  logic [RES_W-1:0] placed_i,
  input  logic             left_i,
  input  logic             arith_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [RES_W-1:0] shifted_o,
  output logic             lost_o
);
  logic [RES_W-1:0] l_res, l_back_a, l_back_l;
  logic [RES_W-1:0] r_res_a, r_res_l, r_res, r_back;

  // loss check: undo the shift and compare against the placed word
  always_comb begin
    l_res    = placed_i << amt_i;
    l_back_a = $signed(l_res) >>> amt_i;
    l_back_l = l_res >> amt_i;
    r_res_a  = $signed(placed_i) >>> amt_i;
    r_res_l  = placed_i >> amt_i;
    r_res    = arith_i ? r_res_a : r_res_l;
    r_back   = r_res << amt_i;
    if (left_i) begin
      shifted_o = l_res;
      lost_o    = (arith_i ? l_back_a : l_back_l) != placed_i;
    end else begin
      shifted_o = r_res;
      lost_o    = r_back != placed_i;
    end
  end
endmodule

// File: rtl/shf_word_shifter.sv
module shf_word_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int RES_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cond_i,
  input  logic [1:0]        op_i,
  input  logic              hi_i,
  input  logic              or_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [RES_W-1:0]  result_o,
  output logic              ovf_o
);
  localparam int AMT_W = CODE_W + 1;

  shf_op_e          op;
  logic             is_norm, arith, left;
  logic [AMT_W-1:0] amt;
  logic [RES_W-1:0] placed, shifted, result_q;
  logic             lost, ovf_q;

  always_comb begin
    op      = shf_op_e'(op_i);
    is_norm = (op == SHF_NORM);
    arith   = (op == SHF_ASH) || (is_norm && hi_i);
  end

  shf_place #(.DATA_W(DATA_W), .RES_W(RES_W)) u_place (
    .operand_i (operand_i),
    .hi_i      (hi_i),
    .arith_i   (arith),
    .placed_o  (placed)
  );

  shf_code #(.CODE_W(CODE_W)) u_code (
    .code_i   (code_i),
    .negate_i (is_norm),
    .left_o   (left),
    .amt_o    (amt)
  );

  shf_barrel #(.RES_W(RES_W), .AMT_W(AMT_W)) u_barrel (
    .placed_i  (placed),
    .left_i    (left),
    .arith_i   (arith),
    .amt_i     (amt),
    .shifted_o (shifted),
    .lost_o    (lost)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else if (cond_i) begin
      result_q <= or_i ? (result_q | shifted) : shifted;
      ovf_q    <= lost;
    end
  end

  assign result_o = result_q;
  assign ovf_o    = ovf_q;
endmodule

// File: rtl/shf_word_shifter_chk.sv
module shf_word_shifter_chk #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 8,
  parameter int RES_W  = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cond_i,
  input logic [1:0]        op_i,
  input logic              hi_i,
  input logic              or_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [CODE_W-1:0] code_i,
  input logic [RES_W-1:0]  result_o,
  input logic              ovf_o
);
  localparam int FIELD_W = 2 * DATA_W;

  assert_noop_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> ($stable(result_o) && $stable(ovf_o)));

  assert_or_keeps_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && or_i) |=> ((result_o & $past(result_o)) == $past(result_o)));

  assert_logical_right_top_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && !or_i && op_i == 2'd1 && code_i[CODE_W-1])
      |=> (result_o[RES_W-1:FIELD_W] == '0));

  assert_hi_left_low_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && !or_i && hi_i && op_i != 2'd2 && !code_i[CODE_W-1])
      |=> (result_o[DATA_W-1:0] == '0));

  assert_zero_code_no_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && code_i == '0) |=> !ovf_o);

  always @(negedge clk_i)
    if (!rst_ni) assert_reset_clear_R1: assert (result_o == '0 && !ovf_o);
endmodule

bind shf_word_shifter shf_word_shifter_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .RES_W(RES_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cond_i    (cond_i),
  .op_i      (op_i),
  .hi_i      (hi_i),
  .or_i      (or_i),
  .operand_i (operand_i),
  .code_i    (code_i),
  .result_o  (result_o),
  .ovf_o     (ovf_o)
);

// File: tb/shf_word_shifter_tb.sv
`timescale 1ns/1ps
module shf_word_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cond = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        hi = 1'b0;
  logic        orm = 1'b0;
  logic [15:0] operand = '0;
  logic [7:0]  code = '0;
  logic [39:0] result;
  logic        ovf;

  int errors = 0;
  int checks = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  shf_word_shifter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .op_i(op), .hi_i(hi),
    .or_i(orm), .operand_i(operand), .code_i(code), .result_o(result), .ovf_o(ovf)
  );

  // {op, hi, operand, code, expected result, expected flag}
  localparam int NV = 13;
  localparam logic [67:0] VEC [NV] = '{
    {2'd0, 1'b1, 16'hB6A3, 8'd3,   40'hFDB5180000, 1'b0},
    {2'd1, 1'b0, 16'hFF6A, 8'd3,   40'h000007FB50, 1'b0},
    {2'd1, 1'b1, 16'h8001, 8'hFC,  40'h0008001000, 1'b0},
    {2'd0, 1'b1, 16'h8001, 8'hFC,  40'hFFF8001000, 1'b0},
    {2'd0, 1'b0, 16'h0003, 8'hFF,  40'h0000000001, 1'b1},
    {2'd0, 1'b0, 16'h4000, 8'd25,  40'h8000000000, 1'b1},
    {2'd0, 1'b0, 16'h4000, 8'd24,  40'h4000000000, 1'b0},
    {2'd2, 1'b1, 16'hF6D4, 8'hFE,  40'hFFDB500000, 1'b0},
    {2'd2, 1'b0, 16'h04A2, 8'hFE,  40'h0000001288, 1'b0},
    {2'd1, 1'b1, 16'h1234, 8'd127, 40'h0000000000, 1'b1},
    {2'd0, 1'b1, 16'h8000, 8'h80,  40'hFFFFFFFFFF, 1'b1},
    {2'd2, 1'b1, 16'h0001, 8'h80,  40'h0000000000, 1'b1},
    {2'd1, 1'b0, 16'h0000, 8'd50,  40'h0000000000, 1'b0}
  };

  // bitwise reference: returns {flag, result}
  function automatic logic [40:0] model(input logic [1:0] m_op, input logic m_hi,
                                        input logic [15:0] x, input logic [7:0] c);
    logic [39:0] pl, rs;
    logic        ar, fill, sv;
    int          eff, base;
    ar   = (m_op == 2'd0) || (m_op == 2'd2 && m_hi);
    base = m_hi ? 16 : 0;
    for (int i = 0; i < 40; i++) begin
      int j = i - base;
      pl[i] = (j < 0) ? 1'b0 : (j < 16) ? x[j] : (ar & x[15]);
    end
    eff = $signed(c);
    if (m_op == 2'd2) eff = -eff;
    sv = 1'b0;
    if (eff >= 0) begin
      for (int i = 0; i < 40; i++) rs[i] = (i - eff >= 0) ? pl[i - eff] : 1'b0;
      for (int j = 40 - eff; j < 40; j++)
        if (j >= 0 && pl[j] != (ar ? rs[39] : 1'b0)) sv = 1'b1;
    end else begin
      fill = ar & pl[39];
      for (int i = 0; i < 40; i++) rs[i] = (i - eff <= 39) ? pl[i - eff] : fill;
      for (int j = 0; j < -eff && j < 40; j++) if (pl[j]) sv = 1'b1;
    end
    return {sv, rs};
  endfunction

  task automatic check(input string req, input logic [40:0] act, input logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge; outputs are valid at the next falling edge
  task automatic issue(input logic c, input logic [1:0] o, input logic h, input logic m,
                       input logic [15:0] x, input logic [7:0] k);
    cond = c; op = o; hi = h; orm = m; operand = x; code = k;
    @(negedge clk);
    cond = 1'b0;
  endtask

  function automatic string op_req(input logic [1:0] o);
    return (o == 2'd0) ? "R4" : (o == 2'd2) ? "R6" : "R5";
  endfunction

  task automatic dword(input logic [15:0] w_hi, input logic [15:0] w_lo, input logic [7:0] k);
    logic signed [39:0] v;
    logic [39:0]        exp;
    int                 s;
    v = {{8{w_hi[15]}}, w_hi, w_lo};
    s = $signed(k);
    if (s >= 0) exp = (s >= 40) ? 40'h0 : (v << s);
    else        exp = v >>> (-s);
    issue(1'b1, 2'd0, 1'b1, 1'b0, w_hi, k);
    issue(1'b1, 2'd1, 1'b0, 1'b1, w_lo, k);
    check("R10 double word", {1'b0, result}, {1'b0, exp});
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {ovf, result}, 41'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 placement and direction, R9 flag
    for (int n = 0; n < NV; n++) begin
      logic [67:0] e = VEC[n];
      issue(1'b1, e[67:66], e[65], 1'b0, e[64:49], e[48:41]);
      check({op_req(e[67:66]), " R2 R3 table result"}, {1'b0, result}, {1'b0, e[40:1]});
      check("R9 table flag", {40'h0, ovf}, {40'h0, e[0]});
      check("R3 table model", model(e[67:66], e[65], e[64:49], e[48:41]), {e[0], e[40:1]});
    end

    // R8: condition low leaves result and flag untouched
    issue(1'b1, 2'd0, 1'b0, 1'b0, 16'h0003, 8'hFF);
    issue(1'b0, 2'd1, 1'b1, 1'b0, 16'hFFFF, 8'd0);
    check("R8 no-op", {ovf, result}, {1'b1, 40'h0000000001});
    issue(1'b0, 2'd2, 1'b1, 1'b1, 16'h8000, 8'h80);
    check("R8 no-op with or", {ovf, result}, {1'b1, 40'h0000000001});

    // R7: OR merge vs overwrite
    issue(1'b1, 2'd1, 1'b0, 1'b0, 16'h00F0, 8'd0);
    issue(1'b1, 2'd1, 1'b1, 1'b1, 16'h0F00, 8'd0);
    check("R7 or merge", {1'b0, result}, {1'b0, 40'h000F0000F0});
    issue(1'b1, 2'd1, 1'b0, 1'b0, 16'h000F, 8'd0);
    check("R7 overwrite", {1'b0, result}, {1'b0, 40'h000000000F});

    // R10 double-word sequences
    dword(16'hB6A3, 16'h765D, 8'd3);
    dword(16'hB6A3, 16'h765D, 8'hFD);
    dword(16'h7FFF, 16'hFFFF, 8'h80);
    dword(16'h8000, 16'h0001, 8'd8);

    // random single operations vs bitwise reference
    for (int n = 0; n < 300; n++) begin
      logic [1:0]  o;
      logic [40:0] exp;
      lfsr = step(lfsr);
      o = (lfsr[1:0] == 2'd3) ? 2'd2 : lfsr[1:0];
      issue(1'b1, o, lfsr[2], 1'b0, lfsr[18:3], lfsr[26:19]);
      exp = model(o, lfsr[2], lfsr[18:3], lfsr[26:19]);
      check({op_req(o), " R3 random result"}, {1'b0, result}, {1'b0, exp[39:0]});
      check("R9 random flag", {40'h0, ovf}, {40'h0, exp[40]});
    end

    for (int n = 0; n < 40; n++) begin
      lfsr = step(lfsr);
      dword(lfsr[15:0], lfsr[31:16], lfsr[23:16]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule